// File: doc/BRIEF.md
# PWM Phase Distributor with Tri-State Recovery

This block takes one pulse-width-modulated input and hands its pulses out in turn to a set of phase outputs. In two-phase mode, successive input pulses alternate between two outputs, so each output runs at half the input rate. In four-phase mode, the pulses rotate through four outputs, so each output runs at a quarter of the input rate. Each output has a drive level and an enable; a low enable stands for a high-impedance output. The mode pin is taken in only while reset is held, and later changes on it have no effect.

A separate flag reports that the input is undriven. While that flag is raised, every enable is pulled low in the same cycle, without waiting for the synchronizer. When the flag clears, the block enters a recovery step in which only phase 0 is enabled. The first high-then-low input pulse goes to phase 0. The rising edge after that pulse restarts normal rotation at phase 1, with all phases of the mode enabled again.

Inside the block, the input level and the undriven flag each pass through a two-flop synchronizer. Rising and falling edges are taken from the synchronized level, and the phase outputs are registered. A pulse edge at the pin therefore reaches its phase output on the third rising clock edge after it.

Top module: `pwm_phase_fanout`

## Requirements
- R1: The mode pin `quad_sel_i` is captured while `rst_n` is low (1 = four phases, 0 = two phases), and any change on it after reset has no effect on the enables or the rotation.
- R2: In two-phase mode, successive input pulses after reset go to phases 0, 1, 0, 1, and so on (phase index = pulse count mod 2).
- R3: In four-phase mode, successive input pulses after reset go to phases 0, 1, 2, 3, 0, and so on (phase index = pulse count mod 4).
- R4: A rising or falling edge of `pwm_in_i` appears on the selected `phase_pwm_o` bit on the third rising clock edge after the input change. Between its two edges the output stays high.
- R5: While `pwm_hiz_i` is high, every bit of `phase_en_o` is 0 in the same cycle, every `phase_pwm_o` bit is 0, and input pulses are ignored.
- R6: When `pwm_hiz_i` clears, `phase_en_o` becomes 4'b0001 on the third rising edge after the change, and the first high-then-low pulse after that (including one already high at that point) is routed only to phase 0.
- R7: The falling edge that ends the recovery pulse restores all enables of the mode, and the next input pulse goes to phase 1, after which rotation continues in order.
- R8: In two-phase mode, `phase_en_o[3:2]` and `phase_pwm_o[3:2]` are always 0, and `phase_en_o` is 4'b0011 outside the undriven and recovery conditions.
- R9: At most one `phase_pwm_o` bit is high at any time, an output is never high while its enable is low, and an enabled phase that is not selected is driven low.
- R10: Directly after reset, `phase_pwm_o` is 0 and `phase_en_o` enables every phase of the captured mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode is captured while it is low |
| quad_sel_i | input | 1 | Mode select: 1 = four phases, 0 = two phases |
| pwm_in_i | input | 1 | PWM input level (asynchronous) |
| pwm_hiz_i | input | 1 | Input-undriven flag (asynchronous) |
| phase_pwm_o | output | PHASES_QUAD (4) | Drive level of each phase output |
| phase_en_o | output | PHASES_QUAD (4) | Enable of each phase output (0 = high impedance) |

## Verification
Every input edge reaches a phase level on the third rising clock edge after the change. The bench therefore drives on a falling edge and samples the outputs on falling edges. It checks after two rising edges that the old value still holds, and after the third that the new value has arrived. The enables behave in two different ways. Raising the undriven flag clears them in the same cycle, so that check is sampled one nanosecond after the drive. Clearing the flag, or ending the recovery pulse, changes them on the third rising edge, and those checks follow the same two-then-three edge rule. The expected phase of every pulse is the running pulse count taken modulo the phase count of the mode. After recovery, the count restarts so that the next pulse lands on phase 1.

// File: rtl/pfo_pkg.sv
package pfo_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_HIZ  = 2'd1,
      ST_SOLO = 2'd2
   } pfo_state_e;
endpackage

// File: rtl/pfo_sync.sv
module pfo_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfo_edge.sv
module pfo_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o,
   output logic fall_o
);
   logic lvl_d;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_d;
   assign fall_o = ~lvl_i & lvl_d;
endmodule

// File: rtl/pfo_sequencer.sv
module pfo_sequencer
   import pfo_pkg::*;
#(
   parameter int PHASES_QUAD = 4,
   parameter int PHASES_DUAL = 2,
   localparam int PW = $clog2(PHASES_QUAD)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          quad_sel_i,
   input  logic          lvl_i,
   input  logic          rise_i,
   input  logic          fall_i,
   input  logic          hiz_i,
   output logic          mode_o,
   output pfo_state_e    st_o,
   output logic [PW-1:0] sel_o,
   output logic          act_o
);
   localparam logic [PW-1:0] LAST_QUAD = PW'(PHASES_QUAD - 1);
   localparam logic [PW-1:0] LAST_DUAL = PW'(PHASES_DUAL - 1);

   logic [PW-1:0] ptr_q;
   logic [PW-1:0] ptr_nxt;
   logic [PW-1:0] last_ph;

   assign last_ph = mode_o ? LAST_QUAD : LAST_DUAL;
   assign ptr_nxt = (ptr_q == last_ph) ? '0 : ptr_q + PW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_o <= quad_sel_i;
         st_o   <= ST_RUN;
         ptr_q  <= '0;
         sel_o  <= '0;
         act_o  <= 1'b0;
      end else begin
         unique case (st_o)
            ST_RUN: begin
               if (hiz_i) begin
                  st_o  <= ST_HIZ;
                  act_o <= 1'b0;
               end else if (rise_i) begin
                  act_o <= 1'b1;
                  sel_o <= ptr_q;
                  ptr_q <= ptr_nxt;
               end else if (fall_i) begin
                  act_o <= 1'b0;
               end
            end
            ST_HIZ: begin
               if (!hiz_i) begin
                  st_o  <= ST_SOLO;
                  sel_o <= '0;
                  act_o <= lvl_i;
               end
            end
            ST_SOLO: begin
               if (hiz_i) begin
                  st_o  <= ST_HIZ;
                  act_o <= 1'b0;
               end else if (rise_i) begin
                  act_o <= 1'b1;
               end else if (fall_i) begin
                  act_o <= 1'b0;
                  st_o  <= ST_RUN;
                  ptr_q <= PW'(1);
               end
            end
            default: begin
               st_o  <= ST_HIZ;
               act_o <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/pfo_outmap.sv
module pfo_outmap
   import pfo_pkg::*;
#(
   parameter int PHASES_QUAD = 4,
   parameter int PHASES_DUAL = 2,
   localparam int PW = $clog2(PHASES_QUAD)
) (
   input  logic                   hiz_raw_i,
   input  logic                   mode_i,
   input  pfo_state_e             st_i,
   input  logic [PW-1:0]          sel_i,
   input  logic                   act_i,
   output logic [PHASES_QUAD-1:0] pwm_o,
   output logic [PHASES_QUAD-1:0] en_o
);
   logic run_st;
   logic solo_st;

   assign run_st  = (st_i == ST_RUN);
   assign solo_st = (st_i == ST_SOLO);

   for (genvar k = 0; k < PHASES_QUAD; k++) begin : g_phase
      logic en_state;
      if (k == 0) begin : g_lead
         assign en_state = run_st | solo_st;
      end else if (k < PHASES_DUAL) begin : g_shared
         assign en_state = run_st;
      end else begin : g_quad_only
         assign en_state = run_st & mode_i;
      end
      assign en_o[k]  = en_state & ~hiz_raw_i;
      assign pwm_o[k] = en_o[k] & act_i & (sel_i == PW'(k));
   end
endmodule

// File: rtl/pwm_phase_fanout.sv
module pwm_phase_fanout
   import pfo_pkg::*;
#(
   parameter int PHASES_QUAD = 4,
   parameter int PHASES_DUAL = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   quad_sel_i,
   input  logic                   pwm_in_i,
   input  logic                   pwm_hiz_i,
   output logic [PHASES_QUAD-1:0] phase_pwm_o,
   output logic [PHASES_QUAD-1:0] phase_en_o
);
   localparam int PW = $clog2(PHASES_QUAD);

   if (PHASES_DUAL < 2) begin : g_bad_dual
      $error("PHASES_DUAL must be at least 2");
   end
   if (PHASES_QUAD <= PHASES_DUAL) begin : g_bad_quad
      $error("PHASES_QUAD must exceed PHASES_DUAL");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [1:0]    sync_q;
   logic          lvl_s;
   logic          hiz_s;
   logic          rise;
   logic          fall;
   logic          mode_q;
   pfo_state_e    st;
   logic [PW-1:0] sel;
   logic          act;

   pfo_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({pwm_hiz_i, pwm_in_i}),
      .q_o   (sync_q)
   );

   assign lvl_s = sync_q[0];
   assign hiz_s = sync_q[1];

   pfo_edge i_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl_s),
      .rise_o (rise),
      .fall_o (fall)
   );

   pfo_sequencer #(.PHASES_QUAD(PHASES_QUAD), .PHASES_DUAL(PHASES_DUAL)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .quad_sel_i (quad_sel_i),
      .lvl_i      (lvl_s),
      .rise_i     (rise),
      .fall_i     (fall),
      .hiz_i      (hiz_s),
      .mode_o     (mode_q),
      .st_o       (st),
      .sel_o      (sel),
      .act_o      (act)
   );

   pfo_outmap #(.PHASES_QUAD(PHASES_QUAD), .PHASES_DUAL(PHASES_DUAL)) i_map (
      .hiz_raw_i (pwm_hiz_i),
      .mode_i    (mode_q),
      .st_i      (st),
      .sel_i     (sel),
      .act_i     (act),
      .pwm_o     (phase_pwm_o),
      .en_o      (phase_en_o)
   );
endmodule

// File: rtl/pfo_chk.sv
module pfo_chk
   import pfo_pkg::*;
#(
   parameter int PHASES_QUAD = 4,
   parameter int PHASES_DUAL = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   pwm_hiz_i,
   input logic [PHASES_QUAD-1:0] phase_pwm_o,
   input logic [PHASES_QUAD-1:0] phase_en_o,
   input logic                   mode_q,
   input pfo_state_e             st
);
   // R5
   hiz_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_hiz_i |-> (phase_en_o == '0));

   // R5
   hiz_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HIZ) |-> (phase_en_o == '0 && phase_pwm_o == '0));

   // R6
   solo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SOLO) |-> (phase_en_o[PHASES_QUAD-1:1] == '0));

   // R8
   dual_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> (phase_en_o[PHASES_QUAD-1:PHASES_DUAL] == '0 &&
                   phase_pwm_o[PHASES_QUAD-1:PHASES_DUAL] == '0));

   // R9
   single_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(phase_pwm_o));

   // R9
   level_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_pwm_o & ~phase_en_o) == '0);

   // R1
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(mode_q));
endmodule

bind pwm_phase_fanout pfo_chk #(.PHASES_QUAD(PHASES_QUAD), .PHASES_DUAL(PHASES_DUAL)) i_pfo_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwm_hiz_i   (pwm_hiz_i),
   .phase_pwm_o (phase_pwm_o),
   .phase_en_o  (phase_en_o),
   .mode_q      (mode_q),
   .st          (st)
);

// File: tb/test_pwm_phase_fanout.sv
module test_pwm_phase_fanout;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       quad_sel = 1'b1;
   logic       pwm_in = 1'b0;
   logic       pwm_hiz = 1'b0;
   logic [3:0] phase_pwm;
   logic [3:0] phase_en;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   pwm_phase_fanout i_pwm_phase_fanout (
      .clk         (clk),
      .rst_n       (rst_n),
      .quad_sel_i  (quad_sel),
      .pwm_in_i    (pwm_in),
      .pwm_hiz_i   (pwm_hiz),
      .phase_pwm_o (phase_pwm),
      .phase_en_o  (phase_en)
   );

   task automatic check(input logic [3:0] actual, input logic [3:0] expected, input string what);
      checks++;
      if (actual !== expected) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", what, actual, expected);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one input pulse expected on phase ph; checks the three-edge lag on both edges
   task automatic pulse(input int ph, input string req);
      logic [3:0] hot;
      hot = 4'(1 << ph);
      pwm_in = 1'b1;
      edges(2);
      check(phase_pwm, 4'b0000, {"R4 rise not before third edge ", req});
      edges(1);
      check(phase_pwm, hot, {"R4 rise on third edge ", req});
      edges(3);
      check(phase_pwm, hot, {"R4 level held ", req});
      pwm_in = 1'b0;
      edges(2);
      check(phase_pwm, hot, {"R4 fall not before third edge ", req});
      edges(1);
      check(phase_pwm, 4'b0000, {"R4 fall on third edge R9 idle low ", req});
      edges(2);
   endtask

   task automatic do_reset(input logic mode);
      rst_n = 1'b0;
      quad_sel = mode;
      edges(5);
      rst_n = 1'b1;
      #1;
      quad_sel = ~mode;
   endtask

   initial begin
      edges(1);
      // four-phase mode
      do_reset(1'b1);
      check(phase_pwm, 4'b0000, "R10 reset level");
      check(phase_en, 4'b1111, "R10 R1 reset enables quad");
      edges(3);
      check(phase_en, 4'b1111, "R1 mode pin change ignored");
      for (int k = 0; k < 9; k++) pulse(k % 4, "R3 quad rotation");
      check(phase_en, 4'b1111, "R1 quad enables after sweep");

      // undriven during a pulse (next phase = 9 mod 4 = 1), exit with input high
      pwm_in = 1'b1;
      edges(4);
      check(phase_pwm, 4'b0010, "R3 pulse on phase 1 before undriven");
      pwm_hiz = 1'b1;
      #1;
      check(phase_en, 4'b0000, "R5 enables drop same cycle");
      check(phase_pwm, 4'b0000, "R5 levels drop same cycle");
      edges(5);
      pwm_in = 1'b0;
      edges(4);
      pwm_in = 1'b1;
      edges(4);
      check(phase_en, 4'b0000, "R5 enables stay low");
      check(phase_pwm, 4'b0000, "R5 input pulse ignored");
      pwm_hiz = 1'b0;
      edges(2);
      check(phase_en, 4'b0000, "R6 enables before third edge");
      edges(1);
      check(phase_en, 4'b0001, "R6 only phase 0 enabled");
      check(phase_pwm, 4'b0001, "R6 high input routed to phase 0");
      pwm_in = 1'b0;
      edges(3);
      check(phase_pwm, 4'b0000, "R6 recovery pulse ends");
      check(phase_en, 4'b1111, "R7 all quad enables restored");
      edges(2);
      for (int k = 0; k < 5; k++) pulse((k + 1) % 4, "R7 resume at phase 1");

      // undriven with input low, exit with input low
      pwm_hiz = 1'b1;
      #1;
      check(phase_en, 4'b0000, "R5 enables drop same cycle idle");
      edges(6);
      pwm_hiz = 1'b0;
      edges(3);
      check(phase_en, 4'b0001, "R6 only phase 0 enabled low exit");
      check(phase_pwm, 4'b0000, "R6 no level before pulse");
      pulse(0, "R6 first pulse to phase 0");
      check(phase_en, 4'b1111, "R7 enables restored after pulse");
      for (int k = 0; k < 4; k++) pulse((k + 1) % 4, "R7 rotation after low exit");

      // two-phase mode
      do_reset(1'b0);
      check(phase_pwm, 4'b0000, "R10 reset level dual");
      check(phase_en, 4'b0011, "R10 R8 reset enables dual");
      edges(3);
      check(phase_en, 4'b0011, "R1 mode pin change ignored dual");
      for (int k = 0; k < 6; k++) pulse(k % 2, "R2 dual rotation");
      check(phase_en, 4'b0011, "R8 dual enables after sweep");
      pwm_hiz = 1'b1;
      #1;
      check(phase_en, 4'b0000, "R5 dual enables drop same cycle");
      edges(5);
      pwm_hiz = 1'b0;
      edges(3);
      check(phase_en, 4'b0001, "R6 dual only phase 0 enabled");
      pulse(0, "R6 dual first pulse to phase 0");
      check(phase_en, 4'b0011, "R7 R8 dual enables restored");
      for (int k = 0; k < 4; k++) pulse((k + 1) % 2, "R7 dual resume at phase 1");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog all requirements actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule